// File: doc/BRIEF.md
# Reset and Start-up Time-out Controller

This block brings a small processor core out of reset and tracks why the core was last reset or woken. It takes these inputs:

- an internal power-good level and a brown-out (supply-good) level;
- an active-low master-clear pin;
- a watchdog expiry pulse;
- sleep, interrupt-wake and clear-watchdog requests from the core;
- a two-bit oscillator-mode selector and a tick that marks each oscillator period.

The block runs a power-up timer, which counts reference-clock cycles, and an oscillator start-up timer, which counts oscillator ticks. The two timers run side by side. The core is held in reset until both have finished. The start-up timer only takes part in the two crystal modes.

Four cause flags are kept in a status byte: time-out, power-down, power-on and brown-out. Software can set the power-on and brown-out flags so that a later reset of that kind can be told apart. At each exit from reset the block pulses a "load reset vector" strobe. At each exit from sleep it pulses a "continue at next instruction" strobe instead.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_ok` is low the core is held in reset and `status` reads 8'h0C. The status bits are: bit 3 time-out (TO), bit 2 power-down (PD), bit 1 power-on (POR), bit 0 brown-out (BOR), and bits 7:4 always 0.
- R2: While `mclr_n` is low the time-out does not begin and `core_rst` stays high, however long it is held.
- R3: Count clock edges from the first edge that samples the releasing condition (`por_ok`, `bor_ok` and `mclr_n` all high). `core_rst` falls at edge 2+max(PWRT_CYCLES, k). Here k is the index of the start-up edge (counted from 1 after that first edge) on which the OST_TICKS-th `osc_tick` is sampled. In modes 0 and 1 (external clock, RC) k is 0. Modes 2 and 3 (crystal, low-frequency crystal) use the tick count.
- R4: At release `vec_load` is high for exactly one cycle and `core_run` rises in the same cycle.
- R5: `bor_ok` low resets the core and sets BOR=0, TO=1 and PD=1, leaving POR unchanged. The time-out restarts when `bor_ok` returns high.
- R6: `mclr_n` low during normal run resets the core and leaves TO and PD unchanged. During sleep or wake-up it resets the core and sets TO=1, PD=0.
- R7: A watchdog expiry during run sets TO=0, PD=1 and takes the core through a full reset and time-out ending in `vec_load`.
- R8: `sleep_req` during run sets TO=1, PD=0 and drops `core_run` without asserting `core_rst`.
- R9: Wake-up from sleep works as follows:
  - a watchdog expiry gives TO=0, PD=0;
  - an interrupt wake gives TO=1, PD=0;
  - if both arrive in one cycle, the watchdog wins.
  `core_run` and a one-cycle `resume_next` follow at edge 2+k of the same timing rule as R3, with no power-up timer.
- R10: `clrwdt` during run sets TO=1 and PD=1.
- R11: `sw_set_por` and `sw_set_bor` set POR or BOR to 1. A brown-out in the same cycle as `sw_set_bor` leaves BOR=0.
- R12: `wdt_expire` and `clrwdt` do not change `status` while the core is held in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_ok | input | 1 | Power-good level; low resets the whole block asynchronously |
| bor_ok | input | 1 | Supply-good level; low is a brown-out |
| mclr_n | input | 1 | Master clear, active low |
| wdt_expire | input | 1 | Watchdog expiry pulse |
| sleep_req | input | 1 | Core requests sleep |
| wake_irq | input | 1 | Interrupt wake request |
| clrwdt | input | 1 | Core executed clear-watchdog |
| osc_mode | input | 2 | 0 external, 1 RC, 2 crystal, 3 low-frequency crystal |
| osc_tick | input | 1 | One-cycle mark per oscillator period |
| sw_set_por | input | 1 | Software write setting POR |
| sw_set_bor | input | 1 | Software write setting BOR |
| core_rst | output | 1 | Core held in reset |
| core_run | output | 1 | Core executing |
| vec_load | output | 1 | Pulse: load PC with 0000h |
| resume_next | output | 1 | Pulse: continue at PC+1 |
| status | output | 8 | Reset-cause flags |

## Verification
Two pairs of actions are provoked on the same clock edge.

In the first pair, a software write setting the brown-out flag lands on the edge where `bor_ok` falls. The bench then expects BOR to read 0.

In the second pair, a watchdog expiry and an interrupt wake reach the sleeping core together. The bench expects the watchdog encoding (TO=0, PD=0).

Release timing is swept over all four oscillator modes and several tick rates. In some of these runs the power-up timer dominates and in others the start-up timer does. The bench predicts the release edge from its own tick tally.

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int PWRT_CYCLES = 96000,
  parameter int OST_TICKS   = 1024
) (
  input  logic       clk,
  input  logic       por_ok,
  input  logic       bor_ok,
  input  logic       mclr_n,
  input  logic       wdt_expire,
  input  logic       sleep_req,
  input  logic       wake_irq,
  input  logic       clrwdt,
  input  logic [1:0] osc_mode,
  input  logic       osc_tick,
  input  logic       sw_set_por,
  input  logic       sw_set_bor,
  output logic       core_rst,
  output logic       core_run,
  output logic       vec_load,
  output logic       resume_next,
  output logic [7:0] status
);
  localparam int PW = $clog2(PWRT_CYCLES + 1);
  localparam int OW = $clog2(OST_TICKS + 1);

  typedef enum logic [2:0] {S_HOLD, S_TIME, S_RUN, S_SLEEP, S_WAKE} st_t;

  st_t           st;
  logic [PW-1:0] pwrt_cnt;
  logic [OW-1:0] ost_cnt;
  logic          f_to, f_pd, f_por, f_bor;

  wire crystal   = osc_mode[1];
  wire pwrt_done = (pwrt_cnt == PW'(PWRT_CYCLES));
  wire ost_full  = (ost_cnt == OW'(OST_TICKS));
  wire ost_done  = !crystal || ost_full;

  assign core_rst = (st == S_HOLD) || (st == S_TIME);
  assign core_run = (st == S_RUN);
  assign status   = {4'b0000, f_to, f_pd, f_por, f_bor};

  always_ff @(posedge clk or negedge por_ok) begin
    if (!por_ok) begin
      st          <= S_HOLD;
      pwrt_cnt    <= '0;
      ost_cnt     <= '0;
      f_to        <= 1'b1;
      f_pd        <= 1'b1;
      f_por       <= 1'b0;
      f_bor       <= 1'b0;
      vec_load    <= 1'b0;
      resume_next <= 1'b0;
    end else begin
      vec_load    <= 1'b0;
      resume_next <= 1'b0;
      if (sw_set_por) f_por <= 1'b1;
      if (sw_set_bor) f_bor <= 1'b1;
      if (!bor_ok) begin
        st       <= S_HOLD;
        f_bor    <= 1'b0;
        f_to     <= 1'b1;
        f_pd     <= 1'b1;
        pwrt_cnt <= '0;
        ost_cnt  <= '0;
      end else if (!mclr_n) begin
        if (st == S_SLEEP || st == S_WAKE) begin
          f_to <= 1'b1;
          f_pd <= 1'b0;
        end
        st       <= S_HOLD;
        pwrt_cnt <= '0;
        ost_cnt  <= '0;
      end else begin
        case (st)
          S_HOLD: st <= S_TIME;
          S_TIME: begin
            if (pwrt_done && ost_done) begin
              st       <= S_RUN;
              vec_load <= 1'b1;
              pwrt_cnt <= '0;
              ost_cnt  <= '0;
            end else begin
              if (!pwrt_done) pwrt_cnt <= pwrt_cnt + PW'(1);
              if (crystal && osc_tick && !ost_full) ost_cnt <= ost_cnt + OW'(1);
            end
          end
          S_RUN: begin
            if (wdt_expire) begin
              f_to <= 1'b0;
              f_pd <= 1'b1;
              st   <= S_HOLD;
            end else if (sleep_req) begin
              f_to <= 1'b1;
              f_pd <= 1'b0;
              st   <= S_SLEEP;
            end else if (clrwdt) begin
              f_to <= 1'b1;
              f_pd <= 1'b1;
            end
          end
          S_SLEEP: begin
            if (wdt_expire) begin
              f_to <= 1'b0;
              f_pd <= 1'b0;
              st   <= S_WAKE;
            end else if (wake_irq) begin
              f_to <= 1'b1;
              f_pd <= 1'b0;
              st   <= S_WAKE;
            end
          end
          S_WAKE: begin
            if (ost_done) begin
              st          <= S_RUN;
              resume_next <= 1'b1;
              ost_cnt     <= '0;
            end else if (crystal && osc_tick && !ost_full) begin
              ost_cnt <= ost_cnt + OW'(1);
            end
          end
          default: st <= S_HOLD;
        endcase
      end
    end
  end
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic       clk,
  input logic       por_ok,
  input logic       bor_ok,
  input logic       mclr_n,
  input logic       core_rst,
  input logic       core_run,
  input logic       vec_load,
  input logic       resume_next,
  input logic [7:0] status
);
  // R1
  upper_zero_chk: assert property (@(posedge clk) status[7:4] == 4'b0000);

  // R2
  mclr_hold_chk: assert property (@(posedge clk) disable iff (!por_ok)
    !mclr_n |=> core_rst);

  // R4
  vec_after_rst_chk: assert property (@(posedge clk) disable iff (!por_ok)
    vec_load |-> (core_run && $past(core_rst)));

  // R4
  run_start_chk: assert property (@(posedge clk) disable iff (!por_ok)
    $rose(core_run) |-> (vec_load || resume_next));

  // R5
  brownout_chk: assert property (@(posedge clk) disable iff (!por_ok)
    !bor_ok |=> (core_rst && !status[0]));

  // R9
  resume_from_sleep_chk: assert property (@(posedge clk) disable iff (!por_ok)
    resume_next |-> ($past(!core_rst && !core_run) && core_run));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!por_ok)
    !(vec_load && resume_next) && !(core_rst && core_run));
endmodule

bind rst_seq_ctrl rst_seq_chk i_chk (
  .clk(clk), .por_ok(por_ok), .bor_ok(bor_ok), .mclr_n(mclr_n),
  .core_rst(core_rst), .core_run(core_run), .vec_load(vec_load),
  .resume_next(resume_next), .status(status)
);

// File: tb/test_rst_seq_ctrl.sv
module test_rst_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int P = 40;
  localparam int T = 8;

  logic clk = 0;
  logic por_ok = 0, bor_ok = 1, mclr_n = 1, wdt_expire = 0, sleep_req = 0;
  logic wake_irq = 0, clrwdt = 0, osc_tick = 0, sw_set_por = 0, sw_set_bor = 0;
  logic [1:0] osc_mode = 0;
  logic core_rst, core_run, vec_load, resume_next;
  logic [7:0] status;
  int errors = 0, checks = 0, div = 1, tick_cnt = 0;

  rst_seq_ctrl #(.PWRT_CYCLES(P), .OST_TICKS(T)) i_rst_seq_ctrl (
    .clk(clk), .por_ok(por_ok), .bor_ok(bor_ok), .mclr_n(mclr_n),
    .wdt_expire(wdt_expire), .sleep_req(sleep_req), .wake_irq(wake_irq),
    .clrwdt(clrwdt), .osc_mode(osc_mode), .osc_tick(osc_tick),
    .sw_set_por(sw_set_por), .sw_set_bor(sw_set_bor), .core_rst(core_rst),
    .core_run(core_run), .vec_load(vec_load), .resume_next(resume_next),
    .status(status));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    osc_tick = ((tick_cnt % div) == 0);
    tick_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Trigger already driven before this edge; counts edges until release or resume.
  task automatic measure(input int pw, input bit wake, input string req);
    int tally = 0, k = 0, j = 0, got = -1;
    bit xtal = osc_mode[1];
    for (int e = 1; e <= 3000; e++) begin
      @(posedge clk); #1;
      if (e == 1) begin wdt_expire = 0; wake_irq = 0; end
      if (e >= 2 && xtal && osc_tick && tally < T) begin
        tally++;
        if (tally == T) k = e - 1;
      end
      if ((!wake && !core_rst) || (wake && core_run)) begin got = e; break; end
    end
    j = 2 + ((pw > k) ? pw : k);
    chk(req, got, j);
    if (wake) chk({req, " resume_next pulse"}, resume_next, 1);
    else begin
      chk("R4 vec_load pulse", vec_load, 1);
      chk("R4 core_run at release", core_run, 1);
    end
    step();
    chk("R4 single-cycle strobe", vec_load | resume_next, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 3; d++) begin
        div = (d == 0) ? 1 : (d == 1) ? 3 : 8;
        @(negedge clk);
        osc_mode = 2'(m);
        por_ok = 0; bor_ok = 1; mclr_n = (d != 1);
        #1;
        chk("R1 status at power-on", status, 8'h0C);
        chk("R1 core_rst at power-on", core_rst, 1);
        @(negedge clk); por_ok = 1;
        if (d == 1) begin
          repeat (P + 20) step();
          chk("R2 held while mclr low", core_rst, 1);
          @(negedge clk); mclr_n = 1;
        end
        measure(P, 0, "R3 power-on release edge");

        @(negedge clk); sw_set_por = 1; sw_set_bor = 1;
        step(); sw_set_por = 0; sw_set_bor = 0;
        chk("R11 software set flags", status, 8'h0F);

        @(negedge clk); sleep_req = 1; step(); sleep_req = 0;
        chk("R8 sleep status", status, 8'h0B);
        chk("R8 sleep core_run", core_run, 0);
        chk("R8 sleep core_rst", core_rst, 0);
        @(negedge clk); wake_irq = 1;
        measure(0, 1, "R9 interrupt wake edge");
        chk("R9 interrupt wake status", status, 8'h0B);

        @(negedge clk); sleep_req = 1; step(); sleep_req = 0;
        @(negedge clk); wdt_expire = 1;
        measure(0, 1, "R9 watchdog wake edge");
        chk("R9 watchdog wake status", status, 8'h03);

        @(negedge clk); clrwdt = 1; step(); clrwdt = 0;
        chk("R10 clrwdt status", status, 8'h0F);

        @(negedge clk); wdt_expire = 1;
        measure(P + 1, 0, "R7 watchdog reset release edge");
        chk("R7 watchdog reset status", status, 8'h07);

        @(negedge clk); sleep_req = 1; step(); sleep_req = 0;
        @(negedge clk); mclr_n = 0; step();
        chk("R6 mclr in sleep status", status, 8'h0B);
        chk("R6 mclr in sleep core_rst", core_rst, 1);
        @(negedge clk); mclr_n = 1;
        measure(P, 0, "R6 mclr-from-sleep release edge");

        @(negedge clk); bor_ok = 0; sw_set_bor = 1; step(); sw_set_bor = 0;
        chk("R11 brown-out beats software set", status, 8'h0E);
        chk("R5 brown-out core_rst", core_rst, 1);
        repeat (3) step();
        @(negedge clk); bor_ok = 1;
        measure(P, 0, "R5 brown-out release edge");

        @(negedge clk); mclr_n = 0; step();
        chk("R6 mclr in run status unchanged", status, 8'h0E);
        chk("R6 mclr in run core_rst", core_rst, 1);
        @(negedge clk); wdt_expire = 1; clrwdt = 1; step(); wdt_expire = 0; clrwdt = 0;
        chk("R12 events ignored in reset", status, 8'h0E);
        @(negedge clk); mclr_n = 1;
        measure(P, 0, "R3 mclr release edge");

        @(negedge clk); sleep_req = 1; step(); sleep_req = 0;
        @(negedge clk); wdt_expire = 1; wake_irq = 1;
        measure(0, 1, "R9 simultaneous wake edge");
        chk("R9 watchdog wins over interrupt", status, 8'h02);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule